// File: doc/BRIEF.md
# Load-Linked Reservation Unit

This unit carries out the load-linked step of an atomic read-modify-write sequence in a load/store pipeline. It handles two access sizes: a 32-bit word and a 64-bit doubleword. The pipeline hands it a virtual address, a size select, a debug-mode flag and the physical address that translation has already produced for that virtual address.

When the address fits the natural alignment of the size, the unit sends one read to memory and waits for the response. It then returns the loaded value. A word value is sign-extended to the register width. Along with the result, the unit records a reservation made of the physical address, the virtual address, the returned value and a valid flag. A later store-conditional stage reads this reservation. An external invalidate input, driven by a snoop or a context switch, clears the valid flag.

When the address is misaligned, the unit reports an address-error-on-load exception and sends nothing to memory. It saves the faulting virtual address for the trap handler, except when the core is in debug mode.

Top module: `ll_reserve_unit`

## Requirements
- R1: After reset, busy, mem_req, res_valid, exc_valid and link_valid are low, and bad_vaddr, link_paddr, link_vaddr and link_value are zero.
- R2: Alignment depends on the size. A word request (req_dword=0) is misaligned when req_vaddr[1:0] is nonzero. A doubleword request (req_dword=1) is misaligned when req_vaddr[2:0] is nonzero. A word at an address with only bit 2 set is aligned.
- R3: A misaligned request accepted at a clock edge gives, in the following cycle, a one-cycle exc_valid with exc_cause = 5'd4 (address error on load). In that case mem_req stays low, res_valid stays low and busy stays low.
- R4: On a misaligned request with debug_mode low, bad_vaddr takes req_vaddr in the cycle of the exception. With debug_mode high, bad_vaddr keeps its value.
- R5: An aligned request accepted at a clock edge gives exactly one cycle of mem_req in the following cycle. In that cycle mem_addr equals req_paddr and mem_dword equals req_dword.
- R6: busy is high from the cycle of mem_req until the edge at which mem_rvalid is sampled, and low from the next cycle. Requests made while busy is high are ignored.
- R7: In the cycle after mem_rvalid is sampled while busy, res_valid is high for one cycle. res_data is then the sign extension of mem_rdata[31:0] for a word, or mem_rdata unchanged for a doubleword.
- R8: When a load completes, link_paddr, link_vaddr and link_value take the request's physical address, its virtual address and the formatted result. link_valid is set in the same cycle as res_valid.
- R9: link_inval sampled high clears link_valid in the next cycle. This includes the edge at which a load completes, where the clear wins.
- R10: mem_rvalid sampled while busy is low has no effect on any output.
- R11: A misaligned request leaves link_valid, link_paddr, link_vaddr and link_value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Load-linked request |
| req_dword | input | 1 | Size select: 1 for doubleword, 0 for word |
| req_vaddr | input | XLEN | Virtual address of the request |
| req_paddr | input | PA_W | Translated physical address of the request |
| debug_mode | input | 1 | Core is in debug mode |
| busy | output | 1 | A read is outstanding |
| mem_req | output | 1 | One-cycle read request to memory |
| mem_dword | output | 1 | Size of the read |
| mem_addr | output | PA_W | Physical address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | XLEN | Read data |
| res_valid | output | 1 | Result valid, one cycle |
| res_data | output | XLEN | Formatted result |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 5 | Exception cause code |
| bad_vaddr | output | XLEN | Last faulting virtual address |
| link_inval | input | 1 | Clear the reservation |
| link_valid | output | 1 | Reservation is held |
| link_paddr | output | PA_W | Reserved physical address |
| link_vaddr | output | XLEN | Reserved virtual address |
| link_value | output | XLEN | Value loaded by the reservation |

## Verification
The bench runs a word at an address with only bit 2 set, a doubleword at that same kind of address, and every nonzero low pattern for each size. A design that checks alignment with one mask for both sizes either faults on a legal word or sends an illegal doubleword to memory.

Word results carry a set bit 31 and garbage in the upper half, so a design that zero-extends, or passes the upper half through, returns a wrong result. Faults are taken both in and out of debug mode, which catches a design that updates bad_vaddr unconditionally. A fault also must not disturb the reservation.

Other cases are:
- a response in the very cycle of the request;
- a stray response while idle;
- a request made while busy;
- an invalidate that coincides with a completion.

A wrong design would, in turn, hang, produce a phantom result, start a second read, or leave a stale reservation marked valid.

// File: rtl/ll_pkg.sv
package ll_pkg;

  typedef enum logic [4:0] {
    CAUSE_NONE = 5'd0,
    CAUSE_ADEL = 5'd4
  } exc_cause_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ll_state_e;

endpackage

// File: rtl/ll_align_chk.sv
module ll_align_chk #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  logic [$clog2(XLEN/8)-1:0] addr_lo,
  input  logic                      is_dword,
  output logic                      misaligned
);
  localparam int WORD_LSB = $clog2(WORD_W/8);

  always_comb begin
    if (is_dword) misaligned = |addr_lo;
    else          misaligned = |addr_lo[WORD_LSB-1:0];
  end
endmodule

// File: rtl/ll_result_fmt.sv
module ll_result_fmt #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  logic [XLEN-1:0] raw,
  input  logic            is_dword,
  output logic [XLEN-1:0] fmt
);
  localparam int EXT_W = XLEN - WORD_W;

  always_comb begin
    if (is_dword) fmt = raw;
    else          fmt = {{EXT_W{raw[WORD_W-1]}}, raw[WORD_W-1:0]};
  end
endmodule

// File: rtl/ll_link_regs.sv
module ll_link_regs #(
  parameter int XLEN = 64,
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic            inval,
  input  logic [PA_W-1:0] commit_paddr,
  input  logic [XLEN-1:0] commit_vaddr,
  input  logic [XLEN-1:0] commit_value,
  output logic            link_valid,
  output logic [PA_W-1:0] link_paddr,
  output logic [XLEN-1:0] link_vaddr,
  output logic [XLEN-1:0] link_value
);
  logic valid_q, valid_d;
  logic [PA_W-1:0] paddr_q;
  logic [XLEN-1:0] vaddr_q, value_q;

  always_comb begin
    valid_d = valid_q;
    if (commit) valid_d = 1'b1;
    if (inval)  valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      paddr_q <= '0;
      vaddr_q <= '0;
      value_q <= '0;
    end else begin
      valid_q <= valid_d;
      if (commit) begin
        paddr_q <= commit_paddr;
        vaddr_q <= commit_vaddr;
        value_q <= commit_value;
      end
    end
  end

  assign link_valid = valid_q;
  assign link_paddr = paddr_q;
  assign link_vaddr = vaddr_q;
  assign link_value = value_q;

  // R9
  inval_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> !link_valid);

  // R8
  commit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !inval |=> link_valid);
endmodule

// File: rtl/ll_reserve_unit.sv
module ll_reserve_unit
  import ll_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int PA_W   = 40,
  parameter int WORD_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_dword,
  input  logic [XLEN-1:0] req_vaddr,
  input  logic [PA_W-1:0] req_paddr,
  input  logic            debug_mode,
  output logic            busy,
  output logic            mem_req,
  output logic            mem_dword,
  output logic [PA_W-1:0] mem_addr,
  input  logic            mem_rvalid,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data,
  output logic            exc_valid,
  output logic [4:0]      exc_cause,
  output logic [XLEN-1:0] bad_vaddr,
  input  logic            link_inval,
  output logic            link_valid,
  output logic [PA_W-1:0] link_paddr,
  output logic [XLEN-1:0] link_vaddr,
  output logic [XLEN-1:0] link_value
);
  localparam int LO_W = $clog2(XLEN/8);

  ll_state_e       state_q, state_d;
  logic            misaligned;
  logic            accept, take_fault, issue, complete;
  logic [XLEN-1:0] fmt_data;

  logic            pend_dword_q;
  logic [XLEN-1:0] pend_vaddr_q;
  logic [PA_W-1:0] pend_paddr_q;
  logic            mem_req_q, mem_req_d;
  logic            exc_q, exc_d;
  exc_cause_e      cause_q, cause_d;
  logic [XLEN-1:0] bad_q;
  logic            bad_en;
  logic            res_valid_q, res_valid_d;
  logic [XLEN-1:0] res_data_q;

  ll_align_chk #(.XLEN(XLEN), .WORD_W(WORD_W)) u_align (
    .addr_lo    (req_vaddr[LO_W-1:0]),
    .is_dword   (req_dword),
    .misaligned (misaligned)
  );

  ll_result_fmt #(.XLEN(XLEN), .WORD_W(WORD_W)) u_fmt (
    .raw      (mem_rdata),
    .is_dword (pend_dword_q),
    .fmt      (fmt_data)
  );

  ll_link_regs #(.XLEN(XLEN), .PA_W(PA_W)) u_link (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit       (complete),
    .inval        (link_inval),
    .commit_paddr (pend_paddr_q),
    .commit_vaddr (pend_vaddr_q),
    .commit_value (fmt_data),
    .link_valid   (link_valid),
    .link_paddr   (link_paddr),
    .link_vaddr   (link_vaddr),
    .link_value   (link_value)
  );

  // Next-state logic
  always_comb begin
    accept      = (state_q == ST_IDLE) && req_valid;
    take_fault  = accept && misaligned;
    issue       = accept && !misaligned;
    complete    = (state_q == ST_WAIT) && mem_rvalid;
    bad_en      = take_fault && !debug_mode;
    mem_req_d   = issue;
    exc_d       = take_fault;
    cause_d     = take_fault ? CAUSE_ADEL : CAUSE_NONE;
    res_valid_d = complete;
    state_d     = state_q;
    case (state_q)
      ST_IDLE: if (issue)    state_d = ST_WAIT;
      ST_WAIT: if (complete) state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      pend_dword_q <= 1'b0;
      pend_vaddr_q <= '0;
      pend_paddr_q <= '0;
      mem_req_q    <= 1'b0;
      exc_q        <= 1'b0;
      cause_q      <= CAUSE_NONE;
      bad_q        <= '0;
      res_valid_q  <= 1'b0;
      res_data_q   <= '0;
    end else begin
      state_q     <= state_d;
      mem_req_q   <= mem_req_d;
      exc_q       <= exc_d;
      cause_q     <= cause_d;
      res_valid_q <= res_valid_d;
      if (issue) begin
        pend_dword_q <= req_dword;
        pend_vaddr_q <= req_vaddr;
        pend_paddr_q <= req_paddr;
      end
      if (bad_en)   bad_q      <= req_vaddr;
      if (complete) res_data_q <= fmt_data;
    end
  end

  assign busy      = (state_q == ST_WAIT);
  assign mem_req   = mem_req_q;
  assign mem_dword = pend_dword_q;
  assign mem_addr  = pend_paddr_q;
  assign exc_valid = exc_q;
  assign exc_cause = cause_q;
  assign bad_vaddr = bad_q;
  assign res_valid = res_valid_q;
  assign res_data  = res_data_q;

  // R3
  exc_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !mem_req && !res_valid && !busy);

  // R5
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R5
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_rvalid |=> busy);

  // R7
  res_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy && $past(busy));

  // R4
  bad_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |-> $stable(bad_vaddr));
endmodule

// File: tb/ll_reserve_unit_tb.sv
`timescale 1ns/1ps
module ll_reserve_unit_tb;
  localparam int XLEN = 64;
  localparam int PA_W = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_dword, debug_mode, mem_rvalid, link_inval;
  logic [XLEN-1:0] req_vaddr, mem_rdata;
  logic [PA_W-1:0] req_paddr;
  logic busy, mem_req, mem_dword, res_valid, exc_valid, link_valid;
  logic [PA_W-1:0] mem_addr, link_paddr;
  logic [XLEN-1:0] res_data, bad_vaddr, link_vaddr, link_value;
  logic [4:0] exc_cause;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;

  always #2 clk = ~clk;

  ll_reserve_unit #(.XLEN(XLEN), .PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dword(req_dword),
    .req_vaddr(req_vaddr), .req_paddr(req_paddr), .debug_mode(debug_mode),
    .busy(busy), .mem_req(mem_req), .mem_dword(mem_dword), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .res_valid(res_valid),
    .res_data(res_data), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .bad_vaddr(bad_vaddr), .link_inval(link_inval), .link_valid(link_valid),
    .link_paddr(link_paddr), .link_vaddr(link_vaddr), .link_value(link_value)
  );

  // Behavioural reference model, one update per clock edge
  bit          m_busy, m_req, m_dw, m_exc, m_res, m_lv;
  logic [63:0] m_addr, m_bad, m_resd, m_lp, m_lva, m_lval, m_pv;

  function automatic logic [63:0] expect_val(bit dw, logic [63:0] d);
    longint s;
    if (dw) return d;
    s = longint'(int'(d[31:0]));
    return 64'(s);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_req <= 0; m_dw <= 0; m_exc <= 0; m_res <= 0; m_lv <= 0;
      m_addr <= 0; m_bad <= 0; m_resd <= 0; m_lp <= 0; m_lva <= 0; m_lval <= 0; m_pv <= 0;
    end else begin
      bit bad_align;
      m_req <= 0; m_exc <= 0; m_res <= 0;
      bad_align = req_dword ? (req_vaddr % 8 != 0) : (req_vaddr % 4 != 0);
      if (!m_busy && req_valid) begin
        if (bad_align) begin
          m_exc <= 1;
          if (!debug_mode) m_bad <= req_vaddr;
        end else begin
          m_req <= 1; m_busy <= 1; m_addr <= 64'(req_paddr);
          m_dw <= req_dword; m_pv <= req_vaddr;
        end
      end else if (m_busy && mem_rvalid) begin
        m_res <= 1; m_busy <= 0;
        m_resd <= expect_val(m_dw, mem_rdata);
        m_lval <= expect_val(m_dw, mem_rdata);
        m_lp <= m_addr; m_lva <= m_pv;
        m_lv <= !link_inval;
      end
      if (link_inval) m_lv <= 0;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R6", "busy", 64'(busy), 64'(m_busy));
      chk("R5", "mem_req", 64'(mem_req), 64'(m_req));
      if (m_req) begin
        chk("R5", "mem_addr", 64'(mem_addr), m_addr);
        chk("R5", "mem_dword", 64'(mem_dword), 64'(m_dw));
      end
      chk("R3", "exc_valid", 64'(exc_valid), 64'(m_exc));
      if (m_exc) chk("R3", "exc_cause", 64'(exc_cause), 64'd4);
      chk("R4", "bad_vaddr", bad_vaddr, m_bad);
      chk("R7", "res_valid", 64'(res_valid), 64'(m_res));
      if (m_res) chk("R7", "res_data", res_data, m_resd);
      chk("R9", "link_valid", 64'(link_valid), 64'(m_lv));
      chk("R8", "link_paddr", 64'(link_paddr), m_lp);
      chk("R8", "link_vaddr", link_vaddr, m_lva);
      chk("R8", "link_value", link_value, m_lval);
    end
  end

  // Drive one cycle of inputs, then move to the next falling edge
  task automatic step(input bit rv, input bit dw, input logic [63:0] va,
                      input logic [PA_W-1:0] pa, input bit dbg,
                      input bit mv, input logic [63:0] md, input bit inv);
    req_valid = rv; req_dword = dw; req_vaddr = va; req_paddr = pa;
    debug_mode = dbg; mem_rvalid = mv; mem_rdata = md; link_inval = inv;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 64'h0, '0, 0, 0, 64'h0, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] keep_va, keep_val;
    rst_n = 1'b0;
    req_valid = 0; req_dword = 0; req_vaddr = 0; req_paddr = 0;
    debug_mode = 0; mem_rvalid = 0; mem_rdata = 0; link_inval = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "busy", 64'(busy), 0);
    chk("R1", "flags", 64'({mem_req, res_valid, exc_valid, link_valid}), 0);
    chk("R1", "bad_vaddr", bad_vaddr, 0);
    chk("R1", "link regs", link_vaddr | link_value | 64'(link_paddr), 0);
    cmp_en = 1'b1;

    // Word load, negative value with junk in the upper half (R7 sign extension)
    step(1, 0, 64'h1000_0000_0000_1008, 40'h12_3456_7008, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 0, '0, 0, 1, 64'hDEAD_BEEF_8000_0001, 0);
    chk("R7", "word sign extension", res_data, 64'hFFFF_FFFF_8000_0001);
    idle(1);

    // Doubleword, response in the very cycle mem_req is visible
    step(1, 1, 64'h2000, 40'h00_0000_2000, 0, 0, 0, 0);
    step(0, 0, 0, '0, 0, 1, 64'h8123_4567_89AB_CDEF, 0);
    chk("R8", "link_valid after dword", 64'(link_valid), 1);
    idle(1);

    // Misaligned word, debug off
    keep_va = link_vaddr; keep_val = link_value;
    step(1, 0, 64'h3000_0000_0000_1002, 40'h1002, 0, 0, 0, 0);
    chk("R2", "word bits[1:0]=2 faults", 64'(exc_valid), 1);
    chk("R4", "bad_vaddr captured", bad_vaddr, 64'h3000_0000_0000_1002);
    idle(1);
    chk("R11", "link_vaddr kept", link_vaddr, keep_va);
    chk("R11", "link_value kept", link_value, keep_val);
    chk("R11", "link_valid kept", 64'(link_valid), 1);

    // Misaligned doubleword (bit 2 only), debug on: bad_vaddr unchanged
    step(1, 1, 64'h4444_0000_0000_0004, 40'h4, 1, 0, 0, 0);
    chk("R2", "dword bit2 faults", 64'(exc_valid), 1);
    chk("R4", "debug keeps bad_vaddr", bad_vaddr, 64'h3000_0000_0000_1002);
    idle(1);

    // Every nonzero low pattern for both sizes, back to back
    for (int k = 1; k < 8; k++) begin
      step(1, 1, 64'h5000 + 64'(k), 40'h5000, 0, 0, 0, 0);
      chk("R2", "dword low bits fault", 64'(exc_valid), 1);
    end
    for (int k = 1; k < 4; k++) begin
      step(1, 0, 64'h6000 + 64'(k), 40'h6000, 0, 0, 0, 0);
      chk("R2", "word low bits fault", 64'(exc_valid), 1);
    end
    idle(1);

    // Word at bit-2-only address is aligned; request while busy is ignored
    step(1, 0, 64'h7000_0000_0000_00C4, 40'hAB_0000_00C4, 0, 0, 0, 0);
    chk("R2", "word at bit2 aligned", 64'(mem_req), 1);
    step(1, 0, 64'h0000_0000_0000_0001, 40'h1, 0, 0, 0, 0);
    step(1, 1, 64'h8, 40'h8, 0, 0, 0, 0);
    chk("R6", "no exception while busy", 64'(exc_valid), 0);
    chk("R6", "no second mem_req", 64'(mem_req), 0);
    step(0, 0, 0, '0, 0, 1, 64'hFFFF_0000_7FFF_FFFF, 0);
    chk("R7", "positive word", res_data, 64'h0000_0000_7FFF_FFFF);
    idle(1);

    // Stray response while idle
    step(0, 0, 0, '0, 0, 1, 64'h1234, 0);
    chk("R10", "stray rvalid no result", 64'(res_valid), 0);
    chk("R10", "stray rvalid link value", link_value, 64'h0000_0000_7FFF_FFFF);
    idle(1);

    // Invalidate alone
    step(0, 0, 0, '0, 0, 0, 0, 1);
    chk("R9", "inval clears", 64'(link_valid), 0);
    idle(1);

    // Completion with invalidate in the same cycle
    step(1, 1, 64'h9000, 40'h9000, 0, 0, 0, 0);
    idle(1);
    step(0, 0, 0, '0, 0, 1, 64'h0BAD_F00D_0000_0001, 1);
    chk("R9", "inval wins over commit", 64'(link_valid), 0);
    chk("R7", "result still delivered", 64'(res_valid), 1);
    idle(1);

    // Long latency, then invalidate later
    step(1, 0, 64'hA008, 40'hA008, 1, 0, 0, 0);
    idle(6);
    step(0, 0, 0, '0, 0, 1, 64'h0000_0000_0000_0042, 0);
    chk("R8", "link after long wait", link_paddr, 40'hA008);
    idle(2);
    step(0, 0, 0, '0, 0, 0, 0, 1);
    idle(2);

    summary();
  end
endmodule